// File: doc/BRIEF.md
# Variable-Precision Multiply-Accumulate Slice

The slice is a signed multiply-accumulate element whose arithmetic shape is chosen per operation by a mode input. It can run as a pair of 18x18 multipliers whose products are added, as a pair of 18x18 multipliers whose results stay separate, or as a single 27x27 multiplier. Before each multiplier, an optional pre-adder can add a second data operand to the first one or subtract it. The second factor of each multiplier comes either from an input port or from a small internal coefficient store, and the store entry is chosen every cycle.

After the multipliers sits a 64-bit accumulator. On each operation it can take the new sum as is, add it to the held value, subtract it from the held value, or load an external value. A cascade input lets the result of a neighbouring slice join the sum, and a cascade output passes this slice's result on to the next one. In this way a column of slices forms a systolic filter. An external addend gives an A×B+C form. A rounded and truncated copy of the accumulator is also provided for the next processing stage.

All control inputs are captured along with the operands. This lets the mode, the pre-adder setting and the accumulator operation change on any cycle without disturbing operations already in flight.

Top module: `vp_mac_slice`

## Requirements
- R1: The result appears two clock edges after the operands are presented: one input register and one accumulator register. A synchronous active-high reset clears `res`, `cas_out` and `res_rnd` to zero.
- R2: With `mode_sel`=00 (paired sum), `res` before the accumulator operation equals the sign-extended sum of two signed 18x18 products, A0*B0 + A1*B1.
- R3: With `mode_sel`=01 (split), `res[31:0]` holds the low 32 bits of A0*B0 and `res[63:32]` holds the low 32 bits of A1*B1. In this mode `acc_op`, `cas_en`, `cas_in`, `c_en` and `add_c` have no effect.
- R4: With `mode_sel`=10 or 11 (wide), the sum is the sign-extended signed product of a 27-bit A and a 27-bit B.
- R5: In the two 18-bit modes, `pre_op`=01 makes Ai = Xi + Yi and `pre_op`=10 makes Ai = Xi − Yi. Both results wrap to 18 bits in two's complement. `pre_op`=00 or 11 makes Ai = Xi.
- R6: In wide mode, an active pre-adder sign-extends `wa[25:0]` and `wy` to 27 bits before it adds or subtracts them. A bypassed pre-adder passes the full 27-bit `wa`.
- R7: With `coef_use`=1, B comes from the coefficient store instead of the `c0`, `c1` or `wc` ports. The first store (27 bits x 8, index `coef_sel0`) feeds lane 0 through its low 18 bits and feeds wide mode through all 27 bits. The second store (18 bits x 8, index `coef_sel1`) feeds lane 1. A write with `coef_we` goes to store `coef_wbank` at `coef_waddr` on the clock edge. A read on the same edge returns the old contents.
- R8: `acc_op`=00 makes the new result equal the sum. `acc_op`=01 adds the sum to the previous result, and `acc_op`=10 subtracts the sum from it. All arithmetic is modulo 2^64.
- R9: `acc_op`=11 loads `add_c` into the accumulator, and the product is not used.
- R10: When `cas_en`=1, `cas_in` is added to the sum. `cas_out` always equals `res`.
- R11: When `c_en`=1, `add_c` is added to the sum (A×B+C). The result can leave directly (`acc_op`=00) or be accumulated.
- R12: `res_rnd` equals bits 63:16 of (`res` + 2^15), which rounds the accumulator half-up to 48 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 00 paired sum, 01 split, 1x wide |
| pre_op | input | 2 | 00/11 bypass, 01 add, 10 subtract |
| coef_use | input | 1 | Take B from the coefficient store |
| coef_sel0 | input | 3 | Read index, first store |
| coef_sel1 | input | 3 | Read index, second store |
| coef_we | input | 1 | Coefficient write enable |
| coef_wbank | input | 1 | Store written: 0 first, 1 second |
| coef_waddr | input | 3 | Coefficient write index |
| coef_wdata | input | 27 | Coefficient write data (second store takes bits 17:0) |
| x0 | input | 18 | Lane 0 first pre-adder operand |
| y0 | input | 18 | Lane 0 second pre-adder operand |
| c0 | input | 18 | Lane 0 B operand from port |
| x1 | input | 18 | Lane 1 first pre-adder operand |
| y1 | input | 18 | Lane 1 second pre-adder operand |
| c1 | input | 18 | Lane 1 B operand from port |
| wa | input | 27 | Wide A operand |
| wy | input | 26 | Wide second pre-adder operand |
| wc | input | 27 | Wide B operand from port |
| cas_en | input | 1 | Add the cascade input |
| cas_in | input | 64 | Cascade input from the previous slice |
| c_en | input | 1 | Add the external addend |
| add_c | input | 64 | External addend and load value |
| acc_op | input | 2 | 00 pass, 01 add, 10 subtract, 11 load |
| res | output | 64 | Accumulator result |
| res_rnd | output | 48 | Rounded, truncated result |
| cas_out | output | 64 | Cascade output to the next slice |

## Verification
Every operation issued before a clock edge shows up on `res`, `cas_out` and `res_rnd` after the second edge. A coefficient-store write is visible to reads issued from the following cycle onward. The bench keeps a two-deep queue of expected values. It issues one operation per cycle at the falling edge and, after the next rising edge, compares the outputs against the entry that was queued two operations earlier. Because its model accumulator advances one operation per cycle, back-to-back accumulation, mode switches between consecutive operations and same-edge store writes are all checked at the exact cycle their results land.

// File: rtl/vp_mac_pkg.sv
package vp_mac_pkg;

    // Datapath widths
    localparam int NW       = 18;              // narrow lane operand width
    localparam int WW       = 27;              // wide operand width
    localparam int WPRE     = 26;              // wide pre-adder input width
    localparam int ACC_W    = 64;              // accumulator / cascade width
    localparam int SPLIT_W  = ACC_W / 2;       // per-lane resolution in split mode
    localparam int CDEPTH   = 8;               // coefficient store depth
    localparam int CSEL_W   = $clog2(CDEPTH);  // coefficient index width
    localparam int NLANES   = 2;               // narrow lanes
    localparam int RND_DEF  = 16;              // default rounding position

    typedef enum logic [1:0] {
        MODE_SUM   = 2'b00,
        MODE_SPLIT = 2'b01,
        MODE_WIDE  = 2'b10,
        MODE_WIDE2 = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        PRE_OFF  = 2'b00,
        PRE_ADD  = 2'b01,
        PRE_SUB  = 2'b10,
        PRE_OFF2 = 2'b11
    } preop_e;

    typedef enum logic [1:0] {
        ACC_PASS = 2'b00,
        ACC_ADD  = 2'b01,
        ACC_SUB  = 2'b10,
        ACC_LOAD = 2'b11
    } accop_e;

    // Everything captured by the input register
    typedef struct packed {
        mode_e              mode;
        preop_e             pre;
        accop_e             aop;
        logic               coef_use;
        logic [NW-1:0]      x0;
        logic [NW-1:0]      y0;
        logic [NW-1:0]      c0;
        logic [NW-1:0]      x1;
        logic [NW-1:0]      y1;
        logic [NW-1:0]      c1;
        logic [WW-1:0]      wa;
        logic [WPRE-1:0]    wy;
        logic [WW-1:0]      wc;
        logic               cas_en;
        logic [ACC_W-1:0]   cas;
        logic               c_en;
        logic [ACC_W-1:0]   addc;
    } stage_t;

    function automatic logic is_wide(input mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/vp_coef_bank.sv
module vp_coef_bank #(
    parameter int DATA_W = 27,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read: aligns with the operand input register
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_sel];
        end
    end

endmodule

// File: rtl/vp_preadd.sv
module vp_preadd
    import vp_mac_pkg::*;
#(
    parameter int IN_W  = 18,
    parameter int OUT_W = 18
) (
    input  preop_e           op,
    input  logic [IN_W-1:0]  a,
    input  logic [IN_W-1:0]  b,
    input  logic [OUT_W-1:0] byp,
    output logic [OUT_W-1:0] sum
);

    logic [OUT_W-1:0] ea;
    logic [OUT_W-1:0] eb;

    generate
        if (OUT_W > IN_W) begin : g_extend
            assign ea = {{(OUT_W-IN_W){a[IN_W-1]}}, a};
            assign eb = {{(OUT_W-IN_W){b[IN_W-1]}}, b};
        end else begin : g_wrap
            assign ea = a[OUT_W-1:0];
            assign eb = b[OUT_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (op)
            PRE_ADD: sum = ea + eb;
            PRE_SUB: sum = ea - eb;
            default: sum = byp;
        endcase
    end

endmodule

// File: rtl/vp_accum.sv
module vp_accum
    import vp_mac_pkg::*;
#(
    parameter int RND_LSB = RND_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  mode_e                mode,
    input  accop_e               aop,
    input  logic [2*WW-1:0]      prod_w,
    input  logic [2*NW-1:0]      prod_1,
    input  logic                 cas_en,
    input  logic [ACC_W-1:0]     cas,
    input  logic                 c_en,
    input  logic [ACC_W-1:0]     addc,
    output logic [ACC_W-1:0]     acc_q,
    output logic [ACC_W-RND_LSB-1:0] rnd_q
);

    logic [ACC_W-1:0] pw_x;
    logic [ACC_W-1:0] p1_x;
    logic [ACC_W-1:0] prod_sum;
    logic [ACC_W-1:0] total;
    logic [ACC_W-1:0] acc_d;

    assign pw_x = {{(ACC_W-2*WW){prod_w[2*WW-1]}}, prod_w};
    assign p1_x = {{(ACC_W-2*NW){prod_1[2*NW-1]}}, prod_1};

    always_comb begin
        prod_sum = is_wide(mode) ? pw_x : (pw_x + p1_x);
        total    = prod_sum
                 + (cas_en ? cas  : '0)
                 + (c_en   ? addc : '0);
    end

    always_comb begin
        if (mode == MODE_SPLIT) begin
            acc_d = {prod_1[SPLIT_W-1:0], prod_w[SPLIT_W-1:0]};
        end else begin
            unique case (aop)
                ACC_PASS: acc_d = total;
                ACC_ADD:  acc_d = acc_q + total;
                ACC_SUB:  acc_d = acc_q - total;
                default:  acc_d = addc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // Half-up rounding: upper part plus the bit just below the cut
    assign rnd_q = acc_q[ACC_W-1:RND_LSB]
                 + {{(ACC_W-RND_LSB-1){1'b0}}, acc_q[RND_LSB-1]};

endmodule

// File: rtl/vp_mac_slice.sv
module vp_mac_slice
    import vp_mac_pkg::*;
#(
    parameter int RND_LSB = RND_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               mode_sel,
    input  logic [1:0]               pre_op,
    input  logic                     coef_use,
    input  logic [CSEL_W-1:0]        coef_sel0,
    input  logic [CSEL_W-1:0]        coef_sel1,
    input  logic                     coef_we,
    input  logic                     coef_wbank,
    input  logic [CSEL_W-1:0]        coef_waddr,
    input  logic [WW-1:0]            coef_wdata,
    input  logic [NW-1:0]            x0,
    input  logic [NW-1:0]            y0,
    input  logic [NW-1:0]            c0,
    input  logic [NW-1:0]            x1,
    input  logic [NW-1:0]            y1,
    input  logic [NW-1:0]            c1,
    input  logic [WW-1:0]            wa,
    input  logic [WPRE-1:0]          wy,
    input  logic [WW-1:0]            wc,
    input  logic                     cas_en,
    input  logic [ACC_W-1:0]         cas_in,
    input  logic                     c_en,
    input  logic [ACC_W-1:0]         add_c,
    input  logic [1:0]               acc_op,
    output logic [ACC_W-1:0]         res,
    output logic [ACC_W-RND_LSB-1:0] res_rnd,
    output logic [ACC_W-1:0]         cas_out
);

    // ---------------- input register ----------------
    stage_t s_d;
    stage_t s_q;

    always_comb begin
        s_d.mode     = mode_e'(mode_sel);
        s_d.pre      = preop_e'(pre_op);
        s_d.aop      = accop_e'(acc_op);
        s_d.coef_use = coef_use;
        s_d.x0       = x0;
        s_d.y0       = y0;
        s_d.c0       = c0;
        s_d.x1       = x1;
        s_d.y1       = y1;
        s_d.c1       = c1;
        s_d.wa       = wa;
        s_d.wy       = wy;
        s_d.wc       = wc;
        s_d.cas_en   = cas_en;
        s_d.cas      = cas_in;
        s_d.c_en     = c_en;
        s_d.addc     = add_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- coefficient stores ----------------
    logic [WW-1:0] coef_w;   // first store: 27 bits
    logic [NW-1:0] coef_n;   // second store: 18 bits

    vp_coef_bank #(.DATA_W(WW), .DEPTH(CDEPTH)) u_bank_wide (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coef_we && !coef_wbank),
        .wr_addr (coef_waddr),
        .wr_data (coef_wdata),
        .rd_sel  (coef_sel0),
        .rd_data (coef_w)
    );

    vp_coef_bank #(.DATA_W(NW), .DEPTH(CDEPTH)) u_bank_narrow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coef_we && coef_wbank),
        .wr_addr (coef_waddr),
        .wr_data (coef_wdata[NW-1:0]),
        .rd_sel  (coef_sel1),
        .rd_data (coef_n)
    );

    // ---------------- narrow lanes ----------------
    logic [NW-1:0] lx   [NLANES];
    logic [NW-1:0] ly   [NLANES];
    logic [NW-1:0] lc   [NLANES];
    logic [NW-1:0] lcoef[NLANES];
    logic [NW-1:0] la   [NLANES];
    logic [NW-1:0] lb   [NLANES];

    assign lx[0]    = s_q.x0;
    assign ly[0]    = s_q.y0;
    assign lc[0]    = s_q.c0;
    assign lx[1]    = s_q.x1;
    assign ly[1]    = s_q.y1;
    assign lc[1]    = s_q.c1;
    assign lcoef[0] = coef_w[NW-1:0];
    assign lcoef[1] = coef_n;

    generate
        for (genvar l = 0; l < NLANES; l++) begin : g_lane
            vp_preadd #(.IN_W(NW), .OUT_W(NW)) u_pre (
                .op  (s_q.pre),
                .a   (lx[l]),
                .b   (ly[l]),
                .byp (lx[l]),
                .sum (la[l])
            );
            assign lb[l] = s_q.coef_use ? lcoef[l] : lc[l];
        end
    endgenerate

    // ---------------- wide lane ----------------
    logic [WW-1:0] wide_a;
    logic [WW-1:0] wide_b;

    vp_preadd #(.IN_W(WPRE), .OUT_W(WW)) u_pre_wide (
        .op  (s_q.pre),
        .a   (s_q.wa[WPRE-1:0]),
        .b   (s_q.wy),
        .byp (s_q.wa),
        .sum (wide_a)
    );

    assign wide_b = s_q.coef_use ? coef_w : s_q.wc;

    // ---------------- multipliers ----------------
    // The wide array also serves narrow lane 0; lane 1 has its own 18x18.
    logic signed [WW-1:0]     mul_a;
    logic signed [WW-1:0]     mul_b;
    logic signed [2*WW-1:0]   prod_w;
    logic signed [NW-1:0]     m1_a;
    logic signed [NW-1:0]     m1_b;
    logic signed [2*NW-1:0]   prod_1;

    always_comb begin
        if (is_wide(s_q.mode)) begin
            mul_a = wide_a;
            mul_b = wide_b;
        end else begin
            mul_a = {{(WW-NW){la[0][NW-1]}}, la[0]};
            mul_b = {{(WW-NW){lb[0][NW-1]}}, lb[0]};
        end
    end

    assign prod_w = (2*WW)'(mul_a) * (2*WW)'(mul_b);
    assign m1_a   = la[1];
    assign m1_b   = lb[1];
    assign prod_1 = (2*NW)'(m1_a) * (2*NW)'(m1_b);

    // ---------------- accumulator / output register ----------------
    vp_accum #(.RND_LSB(RND_LSB)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .mode   (s_q.mode),
        .aop    (s_q.aop),
        .prod_w (prod_w),
        .prod_1 (prod_1),
        .cas_en (s_q.cas_en),
        .cas    (s_q.cas),
        .c_en   (s_q.c_en),
        .addc   (s_q.addc),
        .acc_q  (res),
        .rnd_q  (res_rnd)
    );

    assign cas_out = res;

endmodule

// File: rtl/vp_mac_chk.sv
module vp_mac_chk
    import vp_mac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_sel,
    input logic [1:0]        pre_op,
    input logic              coef_use,
    input logic [NW-1:0]     x1,
    input logic [NW-1:0]     c1,
    input logic [WW-1:0]     wa,
    input logic [WW-1:0]     wc,
    input logic              cas_en,
    input logic              c_en,
    input logic [ACC_W-1:0]  add_c,
    input logic [1:0]        acc_op,
    input logic [ACC_W-1:0]  res
);

    logic [ACC_W-1:0]   wide_prod_in;
    logic [ACC_W-1:0]   lane1_prod_in;
    logic [SPLIT_W-1:0] lane1_lo_in;
    logic               plain_ops;

    assign wide_prod_in  = {{(ACC_W-WW){wa[WW-1]}}, wa} * {{(ACC_W-WW){wc[WW-1]}}, wc};
    assign lane1_prod_in = {{(ACC_W-NW){x1[NW-1]}}, x1} * {{(ACC_W-NW){c1[NW-1]}}, c1};
    assign lane1_lo_in   = lane1_prod_in[SPLIT_W-1:0];
    assign plain_ops     = (pre_op == 2'b00 || pre_op == 2'b11) && !coef_use;

    // R1: reset clears the result
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> res == '0);

    // R9: load places add_c into the accumulator two edges later
    a_r9_load_value: assert property (@(posedge clk) disable iff (rst)
        (acc_op == 2'b11 && mode_sel != 2'b01) |=> ##1 (res == $past(add_c, 2)));

    // R4: wide pass-through equals the signed 27x27 product
    a_r4_wide_product: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[1] && acc_op == 2'b00 && plain_ops && !cas_en && !c_en)
        |=> ##1 (res == $past(wide_prod_in, 2)));

    // R3: split mode upper half is lane 1's product
    a_r3_split_upper: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && plain_ops)
        |=> ##1 (res[ACC_W-1:SPLIT_W] == $past(lane1_lo_in, 2)));

    // R8: accumulate adds the new product to the previous result
    a_r8_accum_add: assert property (@(posedge clk) disable iff (rst)
        (mode_sel[1] && acc_op == 2'b01 && plain_ops && !cas_en && !c_en)
        |=> ##1 (res == $past(res, 1) + $past(wide_prod_in, 2)));

endmodule

bind vp_mac_slice vp_mac_chk u_vp_mac_chk (.*);

// File: tb/vp_mac_slice_bench.sv
`timescale 1ns/1ps
module vp_mac_slice_bench;
    import vp_mac_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        mode_sel, pre_op, acc_op;
    logic              coef_use, coef_we, coef_wbank, cas_en, c_en;
    logic [2:0]        coef_sel0, coef_sel1, coef_waddr;
    logic [26:0]       coef_wdata, wa, wc;
    logic [25:0]       wy;
    logic [17:0]       x0, y0, c0, x1, y1, c1;
    logic [63:0]       cas_in, add_c;
    logic [63:0]       res, cas_out;
    logic [47:0]       res_rnd;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    vp_mac_slice u_vp_mac_slice (.*);

    // ---------------- model state ----------------
    logic [63:0] m_acc;
    logic [26:0] m_b0 [8];
    logic [17:0] m_b1 [8];
    logic [63:0] e1, e2;
    bit          v1, v2;
    string       t1, t2;

    function automatic logic signed [63:0] sx(input logic [63:0] v, input int w);
        logic signed [63:0] t;
        t = v << (64 - w);
        return t >>> (64 - w);
    endfunction

    function automatic logic [63:0] model_next();
        logic signed [63:0] a0, b0, a1, b1, aw, bw, p0, p1, pw, s, tot;
        bit on, sub;
        on  = (pre_op == 2'b01) || (pre_op == 2'b10);
        sub = (pre_op == 2'b10);
        a0 = on ? sx(sub ? sx(x0,18) - sx(y0,18) : sx(x0,18) + sx(y0,18), 18) : sx(x0,18);
        a1 = on ? sx(sub ? sx(x1,18) - sx(y1,18) : sx(x1,18) + sx(y1,18), 18) : sx(x1,18);
        b0 = coef_use ? sx(64'(m_b0[coef_sel0][17:0]), 18) : sx(c0, 18);
        b1 = coef_use ? sx(64'(m_b1[coef_sel1]), 18) : sx(c1, 18);
        aw = on ? (sub ? sx(wa,26) - sx(wy,26) : sx(wa,26) + sx(wy,26)) : sx(wa,27);
        bw = coef_use ? sx(64'(m_b0[coef_sel0]), 27) : sx(wc, 27);
        p0 = a0 * b0;
        p1 = a1 * b1;
        pw = aw * bw;
        if (mode_sel == 2'b01) return {p1[31:0], p0[31:0]};
        s   = mode_sel[1] ? pw : p0 + p1;
        tot = s + (cas_en ? cas_in : 64'd0) + (c_en ? add_c : 64'd0);
        case (acc_op)
            2'b00:   return tot;
            2'b01:   return m_acc + tot;
            2'b10:   return m_acc - tot;
            default: return add_c;
        endcase
    endfunction

    function automatic logic [47:0] round_of(input logic [63:0] v);
        logic [63:0] t;
        t = v + 64'h8000;
        return t[63:16];
    endfunction

    task automatic check64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check48(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s res_rnd actual=%h expected=%h (R12)", tag, act, exp);
        end
    endtask

    task automatic idle();
        mode_sel = 2'b10; pre_op = 2'b00; acc_op = 2'b00;
        coef_use = 0; coef_we = 0; coef_wbank = 0; cas_en = 0; c_en = 0;
        coef_sel0 = 0; coef_sel1 = 0; coef_waddr = 0; coef_wdata = 0;
        wa = 0; wc = 0; wy = 0; x0 = 0; y0 = 0; c0 = 0; x1 = 0; y1 = 0; c1 = 0;
        cas_in = 0; add_c = 0;
    endtask

    // Issue the current inputs as one operation; check the one issued two steps back.
    task automatic step(input string tag);
        logic [63:0] e;
        e = model_next();
        m_acc = e;
        if (coef_we) begin
            if (coef_wbank) m_b1[coef_waddr] = coef_wdata[17:0];
            else            m_b0[coef_waddr] = coef_wdata;
        end
        e2 = e1; v2 = v1; t2 = t1;
        e1 = e;  v1 = 1;  t1 = tag;
        @(posedge clk);
        @(negedge clk);
        if (v2) begin
            check64(t2, "res", res, e2);
            check64(t2, "cas_out (R10)", cas_out, e2);
            check48(t2, res_rnd, round_of(e2));
        end
    endtask

    function automatic logic [17:0] r18();
        case ($urandom % 4)
            0: return 18'h1FFFF;
            1: return 18'h20000;
            2: return 18'($urandom);
            default: return 18'($urandom % 16) - 18'd8;
        endcase
    endfunction

    function automatic logic [26:0] r27();
        case ($urandom % 4)
            0: return 27'h3FFFFFF;
            1: return 27'h4000000;
            2: return 27'($urandom);
            default: return 27'($urandom % 16) - 27'd8;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        idle();
        rst = 1;
        m_acc = 0; v1 = 0; v2 = 0;
        for (int i = 0; i < 8; i++) begin m_b0[i] = 0; m_b1[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        check64("R1", "res after reset", res, 64'd0);
        check64("R1", "cas_out after reset", cas_out, 64'd0);
        check48("R1", res_rnd, 48'd0);

        // R7: fill both stores
        for (int i = 0; i < 8; i++) begin
            idle(); coef_we = 1; coef_wbank = 0; coef_waddr = 3'(i);
            coef_wdata = 27'(i * 27'h0123457) ^ 27'h4000001;
            step("R7 fill");
            idle(); coef_we = 1; coef_wbank = 1; coef_waddr = 3'(i);
            coef_wdata = 27'(18'h20000 + 18'(i * 911));
            step("R7 fill");
        end

        // R4: wide most-negative squared
        idle(); mode_sel = 2'b10; wa = 27'h4000000; wc = 27'h4000000; step("R4 min*min");
        idle(); mode_sel = 2'b11; wa = 27'h3FFFFFF; wc = 27'h4000000; step("R4 max*min");
        // R2: paired sum
        idle(); mode_sel = 2'b00; x0 = 18'd3; c0 = -18'sd5; x1 = 18'd7; c1 = 18'd11; step("R2 sum");
        // R5: narrow pre-adder wrap and subtract
        idle(); mode_sel = 2'b00; pre_op = 2'b01; x0 = 18'h1FFFF; y0 = 18'd1; c0 = 18'd1; step("R5 add wrap");
        idle(); mode_sel = 2'b00; pre_op = 2'b10; x1 = 18'h20000; y1 = 18'd1; c1 = 18'd3; step("R5 sub wrap");
        // R6: wide pre-adder
        idle(); pre_op = 2'b01; wa = 27'h1FFFFFF; wy = 26'h1FFFFFF; wc = 27'd2; step("R6 add");
        idle(); pre_op = 2'b10; wa = 27'h2000000; wy = 26'h1FFFFFF; wc = 27'd3; step("R6 sub");
        idle(); pre_op = 2'b11; wa = 27'h7FFFFFF; wy = 26'h1234567; wc = 27'd5; step("R6 bypass");
        // R3: split mode ignores accumulator controls
        idle(); mode_sel = 2'b01; x0 = 18'h20000; c0 = 18'h20000; x1 = 18'h3FFFF; c1 = 18'd5;
        acc_op = 2'b01; cas_en = 1; cas_in = 64'h1111; c_en = 1; add_c = 64'h2222; step("R3 split");
        // R7: reads from the stores, with a same-edge write
        idle(); coef_use = 1; coef_sel0 = 3'd3; wa = 27'd9; step("R7 wide coef");
        idle(); mode_sel = 2'b00; coef_use = 1; coef_sel0 = 3'd5; coef_sel1 = 3'd6;
        x0 = 18'd2; x1 = -18'sd3; coef_we = 1; coef_wbank = 1; coef_waddr = 3'd6; coef_wdata = 27'd77;
        step("R7 narrow coef old-on-write");
        idle(); mode_sel = 2'b00; coef_use = 1; coef_sel1 = 3'd6; x1 = 18'd4; step("R7 written value");
        // R9, R8, R11, R10
        idle(); acc_op = 2'b11; add_c = 64'h0000_0001_0000_0000; step("R9 load");
        idle(); acc_op = 2'b01; wa = 27'd100; wc = 27'd100; step("R8 add");
        idle(); acc_op = 2'b10; wa = 27'd7; wc = -27'sd3; step("R8 sub");
        idle(); acc_op = 2'b00; wa = 27'd6; wc = 27'd7; c_en = 1; add_c = 64'd1000; step("R11 axb+c pass");
        idle(); acc_op = 2'b01; wa = 27'd1; wc = 27'd1; c_en = 1; add_c = -64'sd50; step("R11 axb+c accumulate");
        idle(); wa = 27'd2; wc = 27'd2; cas_en = 1; cas_in = 64'h8000_0000_0000_0000; step("R10 cascade");
        // R12: rounding at the boundary
        idle(); acc_op = 2'b11; add_c = 64'h0000_0000_0001_8000; step("R12 half up");
        idle(); acc_op = 2'b11; add_c = 64'h0000_0000_0001_7FFF; step("R12 below half");
        idle(); acc_op = 2'b11; add_c = 64'hFFFF_FFFF_FFFF_8000; step("R12 negative half");
        idle(); acc_op = 2'b11; add_c = 64'h7FFF_FFFF_FFFF_FFFF; step("R12 top wrap");

        // Random mix across all modes (R2 R3 R4 R5 R6 R7 R8 R11)
        for (int n = 0; n < 600; n++) begin
            mode_sel = 2'($urandom); pre_op = 2'($urandom); acc_op = 2'($urandom);
            coef_use = 1'($urandom); coef_sel0 = 3'($urandom); coef_sel1 = 3'($urandom);
            coef_we = ($urandom % 4) == 0; coef_wbank = 1'($urandom);
            coef_waddr = 3'($urandom); coef_wdata = r27();
            x0 = r18(); y0 = r18(); c0 = r18(); x1 = r18(); y1 = r18(); c1 = r18();
            wa = r27(); wc = r27(); wy = 26'(r27());
            cas_en = 1'($urandom); c_en = 1'($urandom);
            cas_in = {$urandom, $urandom}; add_c = {$urandom, $urandom};
            step("R8 random");
        end
        idle(); step("flush");
        idle(); step("flush");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule